// File: doc/BRIEF.md
# Scanline-Positioned Interrupt Generator

This block raises an interrupt at a chosen raster position. The position is a scanline and a cycle offset within a later frame. After the first firing it can fire again, once per scanline, for a set number of lines. A free-running cycle counter supplies the time base. A one-cycle frame-start strobe records the time at which the current frame began. An arm command gives the line `y`, the horizontal offset `x` and a repeat count. The block computes the first firing time from these. Each firing is one line period later than the previous scheduled time.

Two video standards are supported. In the 60 Hz standard a frame lasts `CLK_HZ/60` cycles and holds `LINES_A` lines. In the 50 Hz standard a frame lasts `CLK_HZ/50` cycles and holds `LINES_B` lines. A line lasts the frame length divided by the line count, rounded down. Every firing sets bit 10 of a status word and emits a one-cycle pulse. The bit stays set until software writes a zero to it.

Top module: `scanline_irq_gen`

## Requirements
- R1: After reset, `irq_status` reads 0 and `fire` stays low. No firing occurs before an arm command, even when frame strobes arrive.
- R2: `std_sel`=0 selects the 60 Hz standard: frame F = CLK_HZ/60 cycles, LINES_A lines, line period P = F/LINES_A. If the last frame strobe was sampled at cycle S, the first firing is due at cycle S + F + (y*F)/LINES_A + x.
- R3: `std_sel`=1 selects the 50 Hz standard with F = CLK_HZ/50, LINES_B lines and P = F/LINES_B, using the same first-firing formula.
- R4: After the first firing, each further firing is due exactly P cycles after the previous scheduled time. P belongs to the standard sampled with the arm command; a later change of `std_sel` has no effect on it. The total number of firings equals the repeat count.
- R5: A repeat count of 0 or 1 gives exactly one firing.
- R6: An arm command discards any pending schedule, reloads the repeat count and suppresses firing in the cycle it is taken.
- R7: A firing due at cycle T sets `irq_status` bit 10 and raises `fire` for one cycle, both visible in cycle T+1. Bit 10 stays set, and every other status bit always reads 0.
- R8: A write (`ack_we`=1) with bit 10 of `ack_wdata` at 0 clears bit 10. A write with bit 10 at 1 leaves it set.
- R9: When a firing and a clearing write fall in the same cycle, bit 10 ends up set.
- R10: Only the frame strobe sampled before the arm command determines the schedule. Strobes after the arm do not move pending firings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse marking the start of a frame |
| std_sel | input | 1 | Video standard: 0 = 60 Hz, 1 = 50 Hz; sampled with the arm command |
| arm_valid | input | 1 | Arm command strobe |
| arm_line | input | 10 | Target scanline y |
| arm_xofs | input | 16 | Horizontal cycle offset x |
| arm_count | input | 8 | Number of firings (0 treated as 1) |
| ack_we | input | 1 | Status write strobe |
| ack_wdata | input | 16 | Status write data; a 0 in bit 10 clears the flag |
| irq_status | output | 16 | Status word; only bit 10 can be set |
| fire | output | 1 | One-cycle pulse per firing |

## Verification
Time in the bench is a cycle count that advances under the same reset rule as the design's counter. A strobe driven during count S is therefore recorded as S. A firing due at count T appears as `fire` high during count T+1, and the bench logs it as T. The logged times are compared, one by one, with the formula values and the line-period steps. Status bits are sampled one cycle after a firing or a write, on the falling edge. For the same-cycle case, the clearing write is driven during count T itself.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

    localparam int TIME_W = 32;
    localparam int LINE_W = 10;
    localparam int XOFS_W = 16;
    localparam int CNT_W  = 8;

    typedef enum logic {
        VSTD_60 = 1'b0,
        VSTD_50 = 1'b1
    } vstd_e;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [XOFS_W-1:0] xofs;
        logic [CNT_W-1:0]  count;
    } arm_cmd_t;

    typedef struct packed {
        logic              active;
        vstd_e             std;
        logic [CNT_W-1:0]  remain;
        logic [TIME_W-1:0] target;
    } sched_t;

    // Cycle offset of scanline y inside a frame of 'frame' cycles and 'lines' lines.
    function automatic logic [TIME_W-1:0] line_offset(
        input logic [LINE_W-1:0] y,
        input int unsigned       frame,
        input int unsigned       lines
    );
        logic [63:0] prod;
        prod = 64'(y) * 64'(frame);
        return TIME_W'(prod / 64'(lines));
    endfunction

    // A count of zero still yields one firing.
    function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
        return (c == '0) ? CNT_W'(1) : c;
    endfunction

endpackage

// File: rtl/scanirq_timebase.sv
module scanirq_timebase
    import scanirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    output logic [TIME_W-1:0] now,
    output logic [TIME_W-1:0] frame_base
);
    logic [TIME_W-1:0] now_q;
    logic [TIME_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q  <= '0;
            base_q <= '0;
        end else begin
            now_q <= now_q + TIME_W'(1);
            if (frame_start) begin
                base_q <= now_q;
            end
        end
    end

    assign now        = now_q;
    assign frame_base = base_q;
endmodule

// File: rtl/scanirq_sched.sv
module scanirq_sched
    import scanirq_pkg::*;
#(
    parameter int unsigned FRAME_A = 564480,
    parameter int unsigned FRAME_B = 677376,
    parameter int unsigned LINES_A = 263,
    parameter int unsigned LINES_B = 314
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now,
    input  logic [TIME_W-1:0] frame_base,
    input  vstd_e             std_sel,
    input  logic              arm_valid,
    input  arm_cmd_t          arm_cmd,
    output logic              hit,
    output logic              fire
);
    localparam int unsigned LINE_A = FRAME_A / LINES_A;
    localparam int unsigned LINE_B = FRAME_B / LINES_B;

    sched_t            st_q, st_d;
    logic              fire_q;
    logic [TIME_W-1:0] lag;
    logic [TIME_W-1:0] first_t;
    logic [TIME_W-1:0] step;

    // Wrap-safe "now has reached target" test.
    assign lag = now - st_q.target;
    assign hit = st_q.active && !arm_valid && !lag[TIME_W-1];

    assign step = (st_q.std == VSTD_50) ? TIME_W'(LINE_B) : TIME_W'(LINE_A);

    always_comb begin
        if (std_sel == VSTD_50) begin
            first_t = frame_base + TIME_W'(FRAME_B)
                    + line_offset(arm_cmd.line, FRAME_B, LINES_B)
                    + TIME_W'(arm_cmd.xofs);
        end else begin
            first_t = frame_base + TIME_W'(FRAME_A)
                    + line_offset(arm_cmd.line, FRAME_A, LINES_A)
                    + TIME_W'(arm_cmd.xofs);
        end
    end

    always_comb begin
        st_d = st_q;
        if (arm_valid) begin
            st_d.active = 1'b1;
            st_d.std    = std_sel;
            st_d.remain = eff_count(arm_cmd.count);
            st_d.target = first_t;
        end else if (hit) begin
            if (st_q.remain > CNT_W'(1)) begin
                st_d.remain = st_q.remain - CNT_W'(1);
                st_d.target = st_q.target + step;
            end else begin
                st_d.active = 1'b0;
                st_d.remain = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '{active: 1'b0, std: VSTD_60, remain: '0, target: '0};
            fire_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            fire_q <= hit;
        end
    end

    assign fire = fire_q;
endmodule

// File: rtl/scanirq_status.sv
module scanirq_status #(
    parameter int STAT_W  = 16,
    parameter int IRQ_BIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              clr_req,
    output logic [STAT_W-1:0] status
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    assign status = STAT_W'(flag_q) << IRQ_BIT;
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
    import scanirq_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 33868800,
    parameter int unsigned LINES_A = 263,
    parameter int unsigned LINES_B = 314,
    parameter int          STAT_W  = 16,
    parameter int          IRQ_BIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              std_sel,
    input  logic              arm_valid,
    input  logic [LINE_W-1:0] arm_line,
    input  logic [XOFS_W-1:0] arm_xofs,
    input  logic [CNT_W-1:0]  arm_count,
    input  logic              ack_we,
    input  logic [STAT_W-1:0] ack_wdata,
    output logic [STAT_W-1:0] irq_status,
    output logic              fire
);
    localparam int unsigned FRAME_A = CLK_HZ / 60;
    localparam int unsigned FRAME_B = CLK_HZ / 50;

    logic [TIME_W-1:0] now;
    logic [TIME_W-1:0] frame_base;
    logic              hit;
    logic              clr_req;
    arm_cmd_t          cmd;
    logic              unused_wdata;

    assign cmd          = '{line: arm_line, xofs: arm_xofs, count: arm_count};
    assign clr_req      = ack_we && !ack_wdata[IRQ_BIT];
    assign unused_wdata = ^ack_wdata;

    scanirq_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .now        (now),
        .frame_base (frame_base)
    );

    scanirq_sched #(
        .FRAME_A(FRAME_A),
        .FRAME_B(FRAME_B),
        .LINES_A(LINES_A),
        .LINES_B(LINES_B)
    ) u_sched (
        .clk       (clk),
        .rst       (rst),
        .now       (now),
        .frame_base(frame_base),
        .std_sel   (vstd_e'(std_sel)),
        .arm_valid (arm_valid),
        .arm_cmd   (cmd),
        .hit       (hit),
        .fire      (fire)
    );

    scanirq_status #(
        .STAT_W (STAT_W),
        .IRQ_BIT(IRQ_BIT)
    ) u_stat (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .clr_req(clr_req),
        .status (irq_status)
    );
endmodule

// File: rtl/scanirq_checker.sv
module scanirq_checker #(
    parameter int STAT_W  = 16,
    parameter int IRQ_BIT = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              arm_valid,
    input logic              ack_we,
    input logic [STAT_W-1:0] ack_wdata,
    input logic [STAT_W-1:0] irq_status,
    input logic              fire
);
    localparam logic [STAT_W-1:0] OWN_MASK = STAT_W'(1) << IRQ_BIT;

    p_fire_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        fire |-> irq_status[IRQ_BIT]);

    p_flag_rise_needs_fire_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_status[IRQ_BIT]) |-> fire);

    p_other_bits_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_status & ~OWN_MASK) == '0);

    p_flag_fall_needs_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_status[IRQ_BIT]) |-> $past(ack_we && !ack_wdata[IRQ_BIT]));

    p_arm_blocks_fire_r6: assert property (@(posedge clk) disable iff (rst)
        $past(arm_valid) |-> !fire);

    p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (rst)
        fire && $past(ack_we) |-> irq_status[IRQ_BIT]);
endmodule

bind scanline_irq_gen scanirq_checker #(
    .STAT_W (STAT_W),
    .IRQ_BIT(IRQ_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .arm_valid (arm_valid),
    .ack_we    (ack_we),
    .ack_wdata (ack_wdata),
    .irq_status(irq_status),
    .fire      (fire)
);

// File: tb/tb_scanline_irq_gen.sv
`timescale 1ns/1ps
module tb_scanline_irq_gen;
    localparam int CLK_HZ  = 9000;
    localparam int LINES_A = 8;
    localparam int LINES_B = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        std_sel = 1'b0;
    logic        arm_valid = 1'b0;
    logic [9:0]  arm_line = '0;
    logic [15:0] arm_xofs = '0;
    logic [7:0]  arm_count = '0;
    logic        ack_we = 1'b0;
    logic [15:0] ack_wdata = '0;
    logic [15:0] irq_status;
    logic        fire;

    int tb_cyc = 0;
    int got[64];
    int ngot = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    scanline_irq_gen #(
        .CLK_HZ (CLK_HZ),
        .LINES_A(LINES_A),
        .LINES_B(LINES_B)
    ) dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .std_sel(std_sel),
        .arm_valid(arm_valid), .arm_line(arm_line), .arm_xofs(arm_xofs),
        .arm_count(arm_count), .ack_we(ack_we), .ack_wdata(ack_wdata),
        .irq_status(irq_status), .fire(fire)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) tb_cyc <= rst ? 0 : tb_cyc + 1;

    always @(negedge clk) begin
        if (!rst && fire && ngot < 64) begin
            got[ngot] = tb_cyc - 1;
            ngot++;
        end
    end

    function automatic int frame_len(bit s);
        return s ? CLK_HZ / 50 : CLK_HZ / 60;
    endfunction
    function automatic int line_len(bit s);
        return frame_len(s) / (s ? LINES_B : LINES_A);
    endfunction
    function automatic int first_due(int s0, int y, int x, bit s);
        return s0 + frame_len(s) + (y * frame_len(s)) / (s ? LINES_B : LINES_A) + x;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe_frame(output int s0);
        @(negedge clk);
        frame_start = 1'b1;
        s0 = tb_cyc;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic arm(int y, int x, int n, bit s);
        @(negedge clk);
        std_sel = s; arm_valid = 1'b1;
        arm_line = 10'(y); arm_xofs = 16'(x); arm_count = 8'(n);
        @(negedge clk);
        arm_valid = 1'b0;
        std_sel = ~s;
    endtask

    task automatic wait_until(int c);
        while (tb_cyc < c) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        ack_we = 1'b1; ack_wdata = 16'hFBFF;
        @(negedge clk);
        ack_we = 1'b0;
        check(irq_status == 16'h0000, "R8 clear by writing 0 to bit10", int'(irq_status), 0);
    endtask

    task automatic run_case(int y, int x, int n, bit s, bit same_cycle_ack, string req);
        int s0, s1, t0, p, nf;
        strobe_frame(s0);
        repeat (3) @(negedge clk);
        ngot = 0;
        arm(y, x, n, s);
        t0 = first_due(s0, y, x, s);
        p  = line_len(s);
        nf = (n == 0) ? 1 : n;
        repeat (4) @(negedge clk);
        strobe_frame(s1);   // R10: must not move the schedule
        if (same_cycle_ack) begin
            wait_until(t0);
            ack_we = 1'b1; ack_wdata = 16'h0000;
            @(negedge clk);
            ack_we = 1'b0;
            check(irq_status[10] == 1'b1, "R9 set wins over clear", int'(irq_status[10]), 1);
        end
        wait_until(t0 + (nf - 1) * p + 6);
        check(ngot == nf, {req, " R4 R5 firing count"}, ngot, nf);
        for (int i = 0; i < nf && i < ngot; i++) begin
            check(got[i] == t0 + i * p, {req, " R2 R3 R4 R10 firing time"}, got[i], t0 + i * p);
        end
        check(irq_status == 16'h0400, "R7 sticky bit10 only", int'(irq_status), 16'h0400);
        @(negedge clk);
        ack_we = 1'b1; ack_wdata = 16'hFFFF;
        @(negedge clk);
        ack_we = 1'b0;
        check(irq_status == 16'h0400, "R8 write with bit10=1 keeps flag", int'(irq_status), 16'h0400);
        clear_flag();
    endtask

    initial begin
        int s0, t0, t1, seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state and no firing without an arm
        check(irq_status == 16'h0000, "R1 status after reset", int'(irq_status), 0);
        check(fire == 1'b0, "R1 fire after reset", int'(fire), 0);
        ngot = 0;
        repeat (2) begin
            strobe_frame(s0);
            repeat (60) @(negedge clk);
        end
        check(ngot == 0, "R1 no firing before arm", ngot, 0);
        check(irq_status == 16'h0000, "R1 status stays clear", int'(irq_status), 0);

        // Directed corners
        run_case(0, 0, 1, 1'b0, 1'b0, "R2");
        run_case(5, 7, 3, 1'b0, 1'b0, "R2");
        run_case(11, 3, 4, 1'b1, 1'b0, "R3");
        run_case(2, 1, 0, 1'b1, 1'b0, "R5");
        run_case(3, 4, 1, 1'b0, 1'b1, "R9");

        // R6: re-arm replaces a pending schedule
        strobe_frame(s0);
        repeat (3) @(negedge clk);
        ngot = 0;
        arm(1, 2, 5, 1'b0);
        t0 = first_due(s0, 1, 2, 1'b0);
        wait_until(t0 + 3);
        arm(3, 0, 2, 1'b1);
        t1 = first_due(s0, 3, 0, 1'b1);
        wait_until(t1 + 5 * line_len(1'b0) + 6);
        check(ngot == 3, "R6 firings after re-arm", ngot, 3);
        check(got[0] == t0, "R6 first schedule fired", got[0], t0);
        check(got[1] == t1, "R6 new schedule first", got[1], t1);
        check(got[2] == t1 + line_len(1'b1), "R6 new schedule repeat", got[2], t1 + line_len(1'b1));
        clear_flag();

        // Constrained random cases
        for (int k = 0; k < 8; k++) begin
            bit s;
            int y, x, n;
            s = 1'($urandom % 2);
            y = int'($urandom % (s ? LINES_B : LINES_A));
            x = int'($urandom % line_len(s));
            n = int'($urandom % 5);
            run_case(y, x, n, s, 1'b0, "R4");
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", tb_cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule